// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block is the control sequencer for a 32-bit RISC datapath that runs each instruction over several clock cycles. It is a Moore state machine with ten numbered states. Every instruction passes through a common fetch state and a common decode state. After decode, the machine follows a short path chosen by the 6-bit opcode, and then it returns to fetch. Register-to-register operations, word loads, word stores, branch-if-equal and jump take three to five cycles each.

The datapath reads the control outputs directly: memory enables, register-file and PC write enables, and the select codes for the ALU operands, the ALU operation class and the next-PC source. All control outputs are registered and track the state register, so the datapath never sees a glitch on them. The current state number is also brought out, so that it can be observed.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 0 and the fetch output settings appear after that edge. This holds in every state, including partway through an instruction.
- R2: State 0 drives `pc_wr_en`=1, `mem_rd`=1, `ir_ld`=1, `addr_sel`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00 and `pc_src`=00, and always moves to state 1. The last state of every instruction (4, 5, 7, 8, 9) moves to state 0.
- R3: State 1 drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00. It then dispatches on `opcode`: 0x23 (load) and 0x2B (store) go to state 2, 0x00 (register op) goes to state 6, 0x04 (branch) goes to state 8, and 0x02 (jump) goes to state 9.
- R4: In state 1, any other opcode returns the machine to state 0. No write enable is asserted on that path.
- R5: State 2 drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. It goes to state 5 if `opcode` is 0x2B at that moment, and to state 3 otherwise.
- R6: State 3 drives `mem_rd`=1 and `addr_sel`=1, then goes to state 4. State 4 drives `rf_wr`=1, `wb_sel`=1 and `dst_sel`=0.
- R7: State 5 drives `mem_wr`=1 and `addr_sel`=1.
- R8: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then goes to state 7. State 7 drives `rf_wr`=1, `dst_sel`=1 and `wb_sel`=0.
- R9: State 8 drives `pc_wr_br`=1, `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01 and `pc_src`=01. `pc_wr_br` is 0 in every other state.
- R10: State 9 drives `pc_wr_en`=1 and `pc_src`=10.
- R11: Every output that a state does not name above is 0 in that state. In particular, `mem_wr`, `rf_wr` and `ir_ld` are never high together.
- R12: `opcode` affects the next state only in states 1 and 2. Changing it in any other state has no effect on the sequence.
- R13: `fsm_state` reports the current state number as an unsigned value from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | OP_W (6) | Opcode field of the held instruction |
| fsm_state | output | 4 | Current state number |
| pc_wr_en | output | 1 | Unconditional PC write |
| pc_wr_br | output | 1 | PC write qualified by the ALU zero flag |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| pc_src | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination field: 0 rt, 1 rd |

## Verification
The assertions are checked on every cycle. They cover the fixed successor states (3 to 4, 6 to 7, and each final state to 0), the return to fetch on an unknown opcode, the limit of the conditional PC write to state 8, the exclusion between the write enables, and the legal range of the state number. Only the bench scenarios can show the exact output vector of each state, the dispatch path for each opcode, the late opcode change at the load/store split, reset applied partway through an instruction, and that opcode changes outside states 1 and 2 are ignored.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BRCH   = 4'd8,
    S_JUMP   = 4'd9
  } st_e;

  typedef enum logic [2:0] {
    C_RTYPE,
    C_LOAD,
    C_STORE,
    C_BRANCH,
    C_JUMP,
    C_NONE
  } cls_e;

  typedef struct packed {
    logic       pc_wr_en;
    logic       pc_wr_br;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_ld;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       dst_sel;
  } ctrl_t;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  logic [OP_W-1:0] opcode,
  output cls_e            cls
);

  always_comb begin
    if (opcode == OP_RTYPE)      cls = C_RTYPE;
    else if (opcode == OP_LOAD)  cls = C_LOAD;
    else if (opcode == OP_STORE) cls = C_STORE;
    else if (opcode == OP_BEQ)   cls = C_BRANCH;
    else if (opcode == OP_JUMP)  cls = C_JUMP;
    else                         cls = C_NONE;
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  st_e  cur,
  input  cls_e cls,
  output st_e  nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (cls)
          C_LOAD, C_STORE: nxt = S_ADDR;
          C_RTYPE:         nxt = S_EXEC;
          C_BRANCH:        nxt = S_BRCH;
          C_JUMP:          nxt = S_JUMP;
          default:         nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (cls == C_STORE) ? S_STWR : S_LDRD;
      S_LDRD:   nxt = S_LDWB;
      S_EXEC:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  st_e   st,
  output ctrl_t ctl
);

  always_comb begin
    ctl = '0;
    unique case (st)
      S_FETCH: begin
        ctl.pc_wr_en  = 1'b1;
        ctl.mem_rd    = 1'b1;
        ctl.ir_ld     = 1'b1;
        ctl.alu_b_sel = 2'b01;
      end
      S_DECODE: ctl.alu_b_sel = 2'b11;
      S_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = 2'b10;
      end
      S_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl.rf_wr  = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      S_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_mode  = 2'b10;
      end
      S_RWB: begin
        ctl.rf_wr   = 1'b1;
        ctl.dst_sel = 1'b1;
      end
      S_BRCH: begin
        ctl.pc_wr_br  = 1'b1;
        ctl.alu_a_sel = 1'b1;
        ctl.alu_mode  = 2'b01;
        ctl.pc_src    = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_wr_en = 1'b1;
        ctl.pc_src   = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output logic [3:0]      fsm_state,
  output logic            pc_wr_en,
  output logic            pc_wr_br,
  output logic            addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_ld,
  output logic            wb_sel,
  output logic [1:0]      pc_src,
  output logic [1:0]      alu_mode,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            rf_wr,
  output logic            dst_sel
);

  st_e   state_q;
  st_e   state_nx;
  st_e   state_d;
  cls_e  op_cls;
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;

  mc_op_classify #(
    .OP_W    (OP_W),
    .OP_RTYPE(OP_RTYPE),
    .OP_LOAD (OP_LOAD),
    .OP_STORE(OP_STORE),
    .OP_BEQ  (OP_BEQ),
    .OP_JUMP (OP_JUMP)
  ) u_cls (
    .opcode(opcode),
    .cls   (op_cls)
  );

  mc_next_state u_nxt (
    .cur(state_q),
    .cls(op_cls),
    .nxt(state_nx)
  );

  assign state_d = rst ? S_FETCH : state_nx;

  // Outputs are decoded from the next state and registered with it,
  // so they change in the same cycle as the state and stay glitch-free.
  mc_out_decode u_dec (
    .st (state_d),
    .ctl(ctrl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctrl_q  <= ctrl_d;
  end

  assign fsm_state = state_q;
  assign pc_wr_en  = ctrl_q.pc_wr_en;
  assign pc_wr_br  = ctrl_q.pc_wr_br;
  assign addr_sel  = ctrl_q.addr_sel;
  assign mem_rd    = ctrl_q.mem_rd;
  assign mem_wr    = ctrl_q.mem_wr;
  assign ir_ld     = ctrl_q.ir_ld;
  assign wb_sel    = ctrl_q.wb_sel;
  assign pc_src    = ctrl_q.pc_src;
  assign alu_mode  = ctrl_q.alu_mode;
  assign alu_a_sel = ctrl_q.alu_a_sel;
  assign alu_b_sel = ctrl_q.alu_b_sel;
  assign rf_wr     = ctrl_q.rf_wr;
  assign dst_sel   = ctrl_q.dst_sel;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'h04,
  parameter logic [OP_W-1:0] OP_JUMP  = 6'h02
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic [3:0]      fsm_state,
  input logic            pc_wr_br,
  input logic            mem_wr,
  input logic            rf_wr,
  input logic            ir_ld
);

  logic op_known;
  assign op_known = (opcode == OP_RTYPE) || (opcode == OP_LOAD) ||
                    (opcode == OP_STORE) || (opcode == OP_BEQ)  ||
                    (opcode == OP_JUMP);

  assert_final_to_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 4'd4 || fsm_state == 4'd5 || fsm_state == 4'd7 ||
     fsm_state == 4'd8 || fsm_state == 4'd9) |=> fsm_state == 4'd0);

  assert_bad_op_R4: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == 4'd1 && !op_known) |=> (fsm_state == 4'd0 && !rf_wr && !mem_wr));

  assert_load_seq_R6: assert property (@(posedge clk) disable iff (rst)
    fsm_state == 4'd3 |=> fsm_state == 4'd4);

  assert_rop_seq_R8: assert property (@(posedge clk) disable iff (rst)
    fsm_state == 4'd6 |=> fsm_state == 4'd7);

  assert_cond_pc_R9: assert property (@(posedge clk) disable iff (rst)
    pc_wr_br |-> fsm_state == 4'd8);

  assert_wr_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, rf_wr, ir_ld}));

  assert_state_range_R13: assert property (@(posedge clk) disable iff (rst)
    fsm_state <= 4'd9);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
  .OP_W    (OP_W),
  .OP_RTYPE(OP_RTYPE),
  .OP_LOAD (OP_LOAD),
  .OP_STORE(OP_STORE),
  .OP_BEQ  (OP_BEQ),
  .OP_JUMP (OP_JUMP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .fsm_state(fsm_state),
  .pc_wr_br (pc_wr_br),
  .mem_wr   (mem_wr),
  .rf_wr    (rf_wr),
  .ir_ld    (ir_ld)
);

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;

  localparam int OP_W = 6;
  localparam int NROW = 6;

  // Stimulus table: opcode, number of observed states, state sequence (first nibble first)
  localparam logic [OP_W-1:0] T_OP  [NROW] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h3F};
  localparam int              T_LEN [NROW] = '{5, 4, 4, 3, 3, 2};
  localparam logic [19:0]     T_SEQ [NROW] = '{20'h01234, 20'h01250, 20'h01670,
                                               20'h01800, 20'h01900, 20'h01000};
  localparam string           T_REQ [NROW] = '{"R6", "R7", "R8", "R9", "R10", "R4"};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [OP_W-1:0] opcode = '0;
  logic [3:0]      fsm_state;
  logic            pc_wr_en, pc_wr_br, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel;
  logic [1:0]      pc_src, alu_mode, alu_b_sel;
  logic            alu_a_sel, rf_wr, dst_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode), .fsm_state(fsm_state),
    .pc_wr_en(pc_wr_en), .pc_wr_br(pc_wr_br), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .dst_sel(dst_sel)
  );

  // Packed view: pc_wr_en,pc_wr_br,addr_sel,mem_rd,mem_wr,ir_ld,wb_sel,pc_src,alu_mode,alu_a_sel,alu_b_sel,rf_wr,dst_sel
  function automatic logic [15:0] act_vec();
    return {pc_wr_en, pc_wr_br, addr_sel, mem_rd, mem_wr, ir_ld, wb_sel,
            pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, dst_sel};
  endfunction

  // Expected control vector per state, from the requirement text
  function automatic logic [15:0] exp_vec(input int s);
    case (s)
      0: return 16'h9404;  // R2
      1: return 16'h000C;  // R3
      2: return 16'h0018;  // R5
      3: return 16'h3000;  // R6
      4: return 16'h0202;  // R6
      5: return 16'h2800;  // R7
      6: return 16'h0050;  // R8
      7: return 16'h0003;  // R8
      8: return 16'h40B0;  // R9
      9: return 16'h8100;  // R10
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check the state number (R13) and the full output vector (R11) at this negedge
  task automatic check_state(input string req, input int s);
    check({req, " R13 state"}, {28'd0, fsm_state}, s);
    check({req, " R11 outputs"}, {16'd0, act_vec()}, {16'd0, exp_vec(s)});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (2) @(negedge clk);
    check_state("R1 reset", 0);
    rst = 1'b0;

    // Table walk: every instruction class from fetch back to fetch
    for (int r = 0; r < NROW; r++) begin
      opcode = T_OP[r];
      for (int i = 0; i < T_LEN[r]; i++) begin
        check_state({T_REQ[r], " R2 R3"}, int'(T_SEQ[r][19-4*i -: 4]));
        @(negedge clk);
      end
    end
    check_state("R2 return", 0);

    // R12: opcode in fetch is ignored; only the value seen in decode matters
    opcode = 6'h3F;
    @(negedge clk);
    check_state("R12 decode", 1);
    opcode = 6'h02;
    @(negedge clk);
    check_state("R12 jump taken", 9);
    @(negedge clk);

    // R12: opcode change during the load read state has no effect
    opcode = 6'h23;
    @(negedge clk);
    @(negedge clk);
    check_state("R12 addr", 2);
    @(negedge clk);
    check_state("R12 load read", 3);
    opcode = 6'h2B;
    @(negedge clk);
    check_state("R12 load wb", 4);
    @(negedge clk);
    check_state("R12 back", 0);

    // R5: the load/store split follows the opcode seen in state 2
    opcode = 6'h23;
    @(negedge clk);
    @(negedge clk);
    check_state("R5 addr", 2);
    opcode = 6'h2B;
    @(negedge clk);
    check_state("R5 late store", 5);
    @(negedge clk);

    // R1: reset partway through a register operation
    opcode = 6'h00;
    @(negedge clk);
    @(negedge clk);
    check_state("R1 mid exec", 6);
    rst = 1'b1;
    @(negedge clk);
    check_state("R1 mid reset", 0);
    @(negedge clk);
    check_state("R1 held", 0);
    rst = 1'b0;
    @(negedge clk);
    check_state("R1 restart", 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule